// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This block collects interrupt requests from two groups of sources and presents them to a processor as one IRQ line. Each group feeds its own 32-channel unit. The units are a primary and a secondary, and they are cascaded. Every channel of a unit picks one source of its own group through a programmable 5-bit index. Each channel also carries an enable bit, a software-force bit and a vector address. Channel numbers set the priority: a lower number beats a higher one. Firmware changes the priority of a source by moving it to a different channel. Any request in the primary unit beats every request in the secondary unit.

The service routine reads the vector register. That read returns the vector address of the current winner, or a programmable default vector when nothing is pending. The same read latches the winner, and from then on requests of equal or lower overall priority are held back. The routine can then read the source-identity register, which reports the unit and source index of the latched request. A write to the end-of-service register releases the mask. Only one level is in service at a time. A request of higher priority still raises IRQ during service, and reading the vector register then returns its vector without replacing the latched one.

The register port is a plain one. A write takes effect at the clock edge on which `reg_wr_i` is high. Read data is combinational on the address while `reg_rd_i` is high. The port has no back-pressure: every access completes in the cycle it is presented. A vector read makes its latch change at the edge that ends the access.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Inside a unit, among the active enabled channels, the one with the lowest channel number wins.
- R2: Any active request of the primary unit wins over every request of the secondary unit.
- R3: `irq_o` is high exactly when at least one unmasked channel is enabled and active. A channel whose enable bit (control bit 5) is 0 never asserts.
- R4: Control bits [4:0] of a channel select which source of its unit drives that channel. When two channels select the same source, both channels become active.
- R5: Control bit 6 forces the channel active regardless of its source, provided that the channel's enable bit is set.
- R6: A read of address 0x100 returns the winner's vector address. If nothing is in service, the read latches the winner. Address 0x101 then returns bit 6 = in service, bit 5 = unit (0 primary, 1 secondary) and bits [4:0] = the source index of the latched request.
- R7: A read of 0x100 while no request is pending returns the default vector held at address 0x102. That register resets to 0 and can be written.
- R8: While a request is in service, requests of equal or lower overall priority are masked. Overall priority puts the primary unit ahead and then orders by channel number. A write to 0x103 ends service, and the mask is released.
- R9: A change on a source, a configuration write, a vector-read latch or an end-of-service write shows on `irq_o` and on the vector read one clock edge later.
- R10: Address layout is {region[8:7], kind[6:5], channel[4:0]}. The regions are 0 = primary, 1 = secondary and 2 = global. Kind 0 is the channel control word and kind 1 is the channel vector. Both read back as written. Everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src_i | input | 32 | Interrupt sources of the primary unit |
| sec_src_i | input | 32 | Interrupt sources of the secondary unit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a vector read latches the winner) |
| reg_addr_i | input | 9 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on the address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The priority result is registered, so every stimulus is due on the clock edge that follows it. This covers a source change, a control or vector write, a latching vector read and an end-of-service write. The bench drives all inputs on the falling edge. It samples `irq_o` and the read data one falling edge later, after exactly one rising edge has passed. A separate check samples `irq_o` before that rising edge to show that the old value is still held. Read data is sampled a moment after the address is presented, before the edge that could latch the request.

// File: rtl/vicc_pkg.sv
package vicc_pkg;
  localparam int unsigned CH_N  = 32;
  localparam int unsigned VEC_W = 32;

  typedef enum logic [1:0] {
    RG_PRIMARY   = 2'd0,
    RG_SECONDARY = 2'd1,
    RG_GLOBAL    = 2'd2,
    RG_UNUSED    = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    UK_CTRL   = 2'd0,
    UK_VECTOR = 2'd1,
    UK_RSV2   = 2'd2,
    UK_RSV3   = 2'd3
  } unit_kind_e;

  typedef enum logic [1:0] {
    GR_VECT   = 2'd0,
    GR_SRCID  = 2'd1,
    GR_DEFVEC = 2'd2,
    GR_EOS    = 2'd3
  } global_reg_e;
endpackage

// File: rtl/vicc_prio_enc.sv
module vicc_prio_enc #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vicc_unit.sv
module vicc_unit #(
  parameter int unsigned CH_N  = 32,
  parameter int unsigned VEC_W = 32,
  localparam int unsigned CH_W  = $clog2(CH_N),
  localparam int unsigned CFG_W = CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_N-1:0]  src_i,
  input  logic             cfg_we_i,
  input  logic             vec_we_i,
  input  logic [CH_W-1:0]  idx_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_rd_o,
  output logic [VEC_W-1:0] vec_rd_o,
  input  logic [CH_W:0]    thr_i,
  output logic             win_valid_o,
  output logic [CH_W-1:0]  win_ch_o,
  output logic [CH_W-1:0]  win_src_o,
  output logic [VEC_W-1:0] win_vec_o
);
  localparam int unsigned EN_BIT  = CH_W;
  localparam int unsigned FRC_BIT = CH_W + 1;

  logic [CFG_W-1:0] cfg_q [CH_N];
  logic [VEC_W-1:0] vec_q [CH_N];
  logic [CH_N-1:0]  act;
  logic [CH_N-1:0]  gated;
  logic             enc_any;
  logic [CH_W-1:0]  enc_idx;
  logic             win_valid_q;
  logic [CH_W-1:0]  win_ch_q;
  logic [CH_W-1:0]  win_src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CH_N; c++) begin
        cfg_q[c] <= '0;
        vec_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < CH_N; c++) begin
        if (cfg_we_i && idx_i == CH_W'(c)) cfg_q[c] <= wdata_i[CFG_W-1:0];
        if (vec_we_i && idx_i == CH_W'(c)) vec_q[c] <= wdata_i;
      end
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assign act[c]   = (src_i[cfg_q[c][CH_W-1:0]] | cfg_q[c][FRC_BIT]) & cfg_q[c][EN_BIT];
    assign gated[c] = act[c] & ((CH_W+1)'(c) < thr_i);
  end

  vicc_prio_enc #(.N(CH_N)) u_enc (
    .req_i (gated),
    .any_o (enc_any),
    .idx_o (enc_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_q <= 1'b0;
      win_ch_q    <= '0;
      win_src_q   <= '0;
    end else begin
      win_valid_q <= enc_any;
      win_ch_q    <= enc_idx;
      win_src_q   <= cfg_q[enc_idx][CH_W-1:0];
    end
  end

  assign cfg_rd_o    = cfg_q[idx_i];
  assign vec_rd_o    = vec_q[idx_i];
  assign win_valid_o = win_valid_q;
  assign win_ch_o    = win_ch_q;
  assign win_src_o   = win_src_q;
  assign win_vec_o   = vec_q[win_ch_q];

  AST_WIN_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_q |-> ({1'b0, win_ch_q} < $past(thr_i))); // R8
  AST_WIN_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_valid_q) |-> $past(|gated)); // R9
  AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|act) |-> !win_valid_q); // R3
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int unsigned CH_N  = vicc_pkg::CH_N,
  parameter int unsigned VEC_W = vicc_pkg::VEC_W,
  localparam int unsigned CH_W   = $clog2(CH_N),
  localparam int unsigned CFG_W  = CH_W + 2,
  localparam int unsigned ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   pri_src_i,
  input  logic [CH_N-1:0]   sec_src_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [VEC_W-1:0]  reg_wdata_i,
  output logic [VEC_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  import vicc_pkg::*;

  localparam int unsigned UNITS = 2;

  region_e     region;
  unit_kind_e  kind;
  global_reg_e greg;
  logic [CH_W-1:0] chi;

  assign region = region_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign kind   = unit_kind_e'(reg_addr_i[CH_W+1:CH_W]);
  assign greg   = global_reg_e'(reg_addr_i[1:0]);
  assign chi    = reg_addr_i[CH_W-1:0];

  logic [CH_N-1:0]  u_src   [UNITS];
  logic [CFG_W-1:0] u_cfgrd [UNITS];
  logic [VEC_W-1:0] u_vecrd [UNITS];
  logic [CH_W:0]    u_thr   [UNITS];
  logic             u_valid [UNITS];
  logic [CH_W-1:0]  u_ch    [UNITS];
  logic [CH_W-1:0]  u_srcid [UNITS];
  logic [VEC_W-1:0] u_vec   [UNITS];

  logic             in_svc_q;
  logic             svc_unit_q;
  logic [CH_W-1:0]  svc_ch_q;
  logic [CH_W-1:0]  svc_src_q;
  logic [VEC_W-1:0] def_vec_q;

  assign u_src[0] = pri_src_i;
  assign u_src[1] = sec_src_i;

  // Mask thresholds: channels below the threshold stay visible.
  assign u_thr[0] = (in_svc_q && !svc_unit_q) ? {1'b0, svc_ch_q} : (CH_W+1)'(CH_N);
  assign u_thr[1] = !in_svc_q ? (CH_W+1)'(CH_N)
                  : (svc_unit_q ? {1'b0, svc_ch_q} : '0);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic cfg_we;
    logic vec_we;
    assign cfg_we = reg_wr_i && region == region_e'(u) && kind == UK_CTRL;
    assign vec_we = reg_wr_i && region == region_e'(u) && kind == UK_VECTOR;

    vicc_unit #(.CH_N(CH_N), .VEC_W(VEC_W)) u_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (u_src[u]),
      .cfg_we_i    (cfg_we),
      .vec_we_i    (vec_we),
      .idx_i       (chi),
      .wdata_i     (reg_wdata_i),
      .cfg_rd_o    (u_cfgrd[u]),
      .vec_rd_o    (u_vecrd[u]),
      .thr_i       (u_thr[u]),
      .win_valid_o (u_valid[u]),
      .win_ch_o    (u_ch[u]),
      .win_src_o   (u_srcid[u]),
      .win_vec_o   (u_vec[u])
    );
  end

  logic             any_win;
  logic             win_unit;
  logic [VEC_W-1:0] win_vec;
  logic             vect_rd;
  logic             eos_wr;
  logic             def_wr;

  assign any_win  = u_valid[0] | u_valid[1];
  assign win_unit = !u_valid[0];
  assign win_vec  = win_unit ? u_vec[1] : u_vec[0];
  assign irq_o    = any_win;

  assign vect_rd = reg_rd_i && region == RG_GLOBAL && greg == GR_VECT;
  assign eos_wr  = reg_wr_i && region == RG_GLOBAL && greg == GR_EOS;
  assign def_wr  = reg_wr_i && region == RG_GLOBAL && greg == GR_DEFVEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q   <= 1'b0;
      svc_unit_q <= 1'b0;
      svc_ch_q   <= '0;
      svc_src_q  <= '0;
      def_vec_q  <= '0;
    end else begin
      if (def_wr) def_vec_q <= reg_wdata_i;
      if (eos_wr) begin
        in_svc_q <= 1'b0;
      end else if (vect_rd && any_win && !in_svc_q) begin
        in_svc_q   <= 1'b1;
        svc_unit_q <= win_unit;
        svc_ch_q   <= win_unit ? u_ch[1] : u_ch[0];
        svc_src_q  <= win_unit ? u_srcid[1] : u_srcid[0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (region)
      RG_PRIMARY, RG_SECONDARY: begin
        if (kind == UK_CTRL)        reg_rdata_o = VEC_W'(u_cfgrd[region[0]]);
        else if (kind == UK_VECTOR) reg_rdata_o = u_vecrd[region[0]];
      end
      RG_GLOBAL: begin
        unique case (greg)
          GR_VECT:   reg_rdata_o = any_win ? win_vec : def_vec_q;
          GR_SRCID:  reg_rdata_o = VEC_W'({in_svc_q, svc_unit_q, svc_src_q});
          GR_DEFVEC: reg_rdata_o = def_vec_q;
          default:   reg_rdata_o = '0;
        endcase
      end
      default: reg_rdata_o = '0;
    endcase
  end

  AST_PRIMARY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid[0] |-> (win_vec == u_vec[0])); // R2
  AST_EOS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    eos_wr |=> !in_svc_q); // R8
  AST_LATCH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc_q) |-> $past(vect_rd)); // R6
  AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (vect_rd && !irq_o) |-> (reg_rdata_o == def_vec_q)); // R7
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEFV = 32'hDEAD0000;
  localparam logic [8:0] A_VECT = 9'h100, A_SRCID = 9'h101, A_DEF = 9'h102, A_EOS = 9'h103;
  localparam int NTAB = 8;
  localparam logic [31:0] TAB_PRI [NTAB] = '{32'h0, 32'h8, 32'h80000000, 32'h0,
                                            32'h00010000, 32'hFFFFFFFF, 32'h0, 32'h00A00000};
  localparam logic [31:0] TAB_SEC [NTAB] = '{32'h0, 32'h0, 32'h1, 32'h300,
                                            32'hFFFFFFFF, 32'h0, 32'h80000000, 32'h0};
  localparam logic [31:0] TAB_VEC [NTAB] = '{DEFV, 32'h100C, 32'h107C, 32'h1120,
                                            32'h1040, 32'h1000, 32'h117C, 32'h1054};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pri = '0, sec = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [4:0] m_sel [2][32];
  logic m_en [2][32];
  logic m_frc [2][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .pri_src_i(pri), .sec_src_i(sec),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [8:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [8:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_ch(input int u, input int c, input logic [4:0] s, input logic en, input logic frc);
    m_sel[u][c] = s; m_en[u][c] = en; m_frc[u][c] = frc;
    wreg(9'(u*128 + c), {25'd0, frc, en, s});
  endtask

  function automatic logic [31:0] vec_of(input int u, input int c);
    return 32'h1000 + 32'(u) * 32'h100 + 32'(c) * 4;
  endfunction

  // Reference model: returns the vector and {valid,unit,source} of the winner
  task automatic model(input logic [31:0] p, input logic [31:0] s,
                       output logic [31:0] v, output logic [31:0] id, output logic hit);
    hit = 1'b0; v = DEFV; id = '0;
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < 32; c++) begin
        if (!hit && m_en[u][c] && (m_frc[u][c] || (u == 0 ? p[m_sel[u][c]] : s[m_sel[u][c]]))) begin
          hit = 1'b1; v = vec_of(u, c); id = {25'd0, 1'b1, 1'(u), m_sel[u][c]};
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ev, eid;
    logic hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R10, R7, R3)
    chk("R3 irq after reset", 32'(irq), 0);
    rreg(9'h005, d); chk("R10 ctrl reset", d, 0);
    rreg(9'h0A3, d); chk("R10 vector reset", d, 0);
    rreg(A_VECT, d); chk("R7 default after reset", d, 0);

    // Configuration: identity map, all enabled
    wreg(A_DEF, DEFV);
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 32; c++) begin
        set_ch(u, c, 5'(c), 1'b1, 1'b0);
        wreg(9'(u*128 + 32 + c), vec_of(u, c));
      end
    rreg(9'h085, d); chk("R10 ctrl readback", d, 32'h25);
    rreg(9'h0A5, d); chk("R10 vector readback", d, 32'h1114);
    rreg(A_DEF, d);  chk("R7 default readback", d, DEFV);

    // Table of vectors (R1, R2, R3, R6, R7)
    for (int i = 0; i < NTAB; i++) begin
      pri = TAB_PRI[i]; sec = TAB_SEC[i];
      @(negedge clk);
      chk("R3 irq table", 32'(irq), 32'(TAB_VEC[i] != DEFV));
      rreg(A_VECT, d); chk("R1/R2 vector table", d, TAB_VEC[i]);
      wreg(A_EOS, 0);
    end

    // R9: one edge of latency
    pri = '0; sec = '0; @(negedge clk);
    pri = 32'h10;
    #1 chk("R9 irq before edge", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq after one edge", 32'(irq), 1);

    // R3: disabled channel does not assert
    pri = '0; set_ch(0, 3, 5'd3, 1'b0, 1'b0);
    pri = 32'h8; @(negedge clk);
    chk("R3 disabled channel irq", 32'(irq), 0);
    rreg(A_VECT, d); chk("R3 disabled -> default", d, DEFV);
    set_ch(0, 3, 5'd3, 1'b1, 1'b0);

    // R4: remap and duplicate selection
    pri = 32'h204;
    set_ch(0, 0, 5'd9, 1'b1, 1'b0);
    set_ch(0, 1, 5'd9, 1'b1, 1'b0);
    @(negedge clk);
    rreg(A_VECT, d); chk("R4 remapped source wins ch0", d, 32'h1000);
    rreg(A_SRCID, d); chk("R6 srcid of remap", d, 32'h49);
    wreg(A_EOS, 0);
    set_ch(0, 0, 5'd9, 1'b0, 1'b0);
    pri = 32'h200; @(negedge clk);
    rreg(A_VECT, d); chk("R4 duplicate on ch1 active", d, 32'h1004);
    wreg(A_EOS, 0);
    set_ch(0, 0, 5'd0, 1'b1, 1'b0);
    set_ch(0, 1, 5'd1, 1'b1, 1'b0);

    // R5: force
    pri = '0; sec = '0;
    set_ch(1, 7, 5'd7, 1'b1, 1'b1);
    @(negedge clk);
    chk("R5 forced irq", 32'(irq), 1);
    rreg(A_VECT, d); chk("R5 forced vector", d, 32'h111C);
    rreg(A_SRCID, d); chk("R6 srcid secondary", d, 32'h67);
    wreg(A_EOS, 0);
    set_ch(1, 7, 5'd7, 1'b0, 1'b1);
    @(negedge clk);
    chk("R5 force without enable", 32'(irq), 0);
    set_ch(1, 7, 5'd7, 1'b1, 1'b0);

    // R8: masking during service
    pri = 32'h400; @(negedge clk);
    rreg(A_VECT, d); chk("R8 latch ch10", d, 32'h1028);
    @(negedge clk);
    chk("R8 served level masked", 32'(irq), 0);
    pri = 32'h1400; sec = 32'h1; @(negedge clk);
    chk("R8 lower levels masked", 32'(irq), 0);
    pri = 32'h1404; @(negedge clk);
    chk("R8 higher still asserts", 32'(irq), 1);
    rreg(A_VECT, d); chk("R8 higher vector", d, 32'h1008);
    rreg(A_SRCID, d); chk("R6 latch kept", d, 32'h4A);
    wreg(A_EOS, 0);
    rreg(A_SRCID, d); chk("R8 service ended", d[6] ? 32'd1 : 32'd0, 0);
    @(negedge clk);
    rreg(A_VECT, d); chk("R8 unmasked winner", d, 32'h1008);
    wreg(A_EOS, 0);

    // Random patterns and remaps against the model (R1..R5)
    for (int k = 0; k < 300; k++) begin
      if (k % 5 == 0)
        set_ch(int'($urandom_range(1)), int'($urandom_range(31)), 5'($urandom),
               1'($urandom_range(3) != 0), 1'($urandom_range(9) == 0));
      pri = $urandom & $urandom; sec = $urandom & $urandom;
      if (k % 7 == 0) pri = '0;
      @(negedge clk);
      model(pri, sec, ev, eid, hit);
      chk("R3 random irq", 32'(irq), 32'(hit));
      rreg(A_VECT, d); chk("R1/R2/R4/R5 random vector", d, ev);
      rreg(A_SRCID, d); chk("R6 random srcid", hit ? d : 32'd0, eid);
      wreg(A_EOS, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule